// File: doc/BRIEF.md
# Dual-Mode 4:2:2 Pixel Output Formatter

This block takes 4:2:2 YCbCr pixels that arrive in irregular bursts and drives them onto an output port in one of two transfer modes. Each input pixel comes with a valid strobe, an active-region flag, a luma byte and both chroma bytes of its pixel pair. A start-of-line pulse marks each line boundary. The block chooses the chroma byte for each pixel from the pixel's position in its line.

In the wide mode, the luma byte and a chroma byte go out side by side on two byte buses, one pixel per output cycle. Every valid pixel is passed, blanking pixels included, and the active flag goes out with it. In the narrow mode, only pixels inside the active region are passed. Each one is serialised onto the luma bus as two words, chroma first and then luma, which gives the repeating stream Cb, Y, Cr, Y. A small FIFO absorbs input bursts while pixels are being expanded. Both modes travel through that same FIFO, so a mode change at a line boundary never reorders or collides data.

Top module: `yc422_port_fmt`

## Requirements
- R1: While reset is held high, dvld_o, active_o, y_o and cbcr_o are all zero.
- R2: In wide mode, every input cycle with in_valid_i high yields exactly one output cycle with dvld_o high, in input order. y_o carries the luma byte. Blanking pixels (in_active_i low) are passed as well.
- R3: In wide mode, the first valid pixel of a line (counted from sol_i) puts its Cb byte on cbcr_o. Later valid pixels alternate Cr, Cb, and so on. Cycles with in_valid_i low do not advance the alternation.
- R4: In wide mode, active_o equals the in_active_i value of the pixel currently on the buses.
- R5: In narrow mode, only pixels with both in_valid_i and in_active_i high are passed. Each one produces two consecutive dvld_o cycles on y_o: first its chroma byte, then its luma byte. The chroma is Cb for the first active pixel of each line and then alternates Cr, Cb, which gives the order Cb, Y, Cr, Y.
- R6: Once narrow mode has taken effect, active_o is high on every output word and stays high while idle.
- R7: On any cycle with dvld_o low, y_o and cbcr_o keep their previous values.
- R8: mode_i (0 = wide, 1 = narrow) is sampled only in a cycle where sol_i is high. A pixel presented in that same cycle already uses the new mode. Changes of mode_i in any other cycle have no effect.
- R9: Pixels leave in arrival order. The FIFO holds DEPTH pixels without loss, as long as narrow-mode input stays within the rate limit stated in the notes.
- R10: When the FIFO is empty and no word is pending, a pixel captured at clock edge k appears on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Requested mode, 0 wide, 1 narrow; taken at sol_i |
| sol_i | input | 1 | Start-of-line pulse, first cycle of a line |
| in_valid_i | input | 1 | Input pixel present this cycle |
| in_active_i | input | 1 | Input pixel lies in the visible region |
| in_y_i | input | DW | Luma byte of the pixel |
| in_cb_i | input | DW | Cb byte of the pixel pair |
| in_cr_i | input | DW | Cr byte of the pixel pair |
| y_o | output | DW | Luma bus (all words in narrow mode) |
| cbcr_o | output | DW | Chroma bus, wide mode only |
| dvld_o | output | 1 | Output word valid |
| active_o | output | 1 | Visible-region flag / narrow-mode indicator |

## Verification
On every cycle, the assertions check that the buses hold when dvld_o is low and that the FIFO is never written while full. They also check that a narrow chroma word is always followed on the next cycle by its luma word with active_o high, and that no valid word appears without buffered data. The Cb/Cr alternation, its restart at each line, the dropping of blanking pixels in narrow mode, the point at which a mode change takes effect and the exact latency are shown only by the bench's scenarios. The bench compares the captured output stream against a stream predicted from the requirements.

// File: rtl/yc422_pkg.sv
package yc422_pkg;

  typedef enum logic {
    XFER_WIDE   = 1'b0,
    XFER_NARROW = 1'b1
  } xfer_mode_e;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/yc422_line_ctrl.sv
module yc422_line_ctrl
  import yc422_pkg::*;
#(
  parameter int DW = 8,
  localparam int EW = 2 * DW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic          sol_i,
  input  logic          valid_i,
  input  logic          active_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] cb_i,
  input  logic [DW-1:0] cr_i,
  output logic          push_o,
  output logic [EW-1:0] ent_o,
  output logic          narrow_o
);

  xfer_mode_e line_mode_q;
  xfer_mode_e eff_mode;
  logic       cr_turn_q;
  logic       eff_turn;
  logic       pass;
  logic [DW-1:0] chroma;

  always_comb begin
    eff_mode = sol_i ? xfer_mode_e'(mode_i) : line_mode_q;
    eff_turn = sol_i ? 1'b0 : cr_turn_q;
    pass     = valid_i && ((eff_mode == XFER_WIDE) || active_i);
    chroma   = eff_turn ? cr_i : cb_i;
  end

  assign push_o   = pass;
  assign ent_o    = {(eff_mode == XFER_NARROW), active_i, chroma, y_i};
  assign narrow_o = (line_mode_q == XFER_NARROW);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_mode_q <= XFER_WIDE;
      cr_turn_q   <= 1'b0;
    end else begin
      if (sol_i) line_mode_q <= xfer_mode_e'(mode_i);
      if (pass)       cr_turn_q <= ~eff_turn;
      else if (sol_i) cr_turn_q <= 1'b0;
    end
  end

endmodule

// File: rtl/yc422_fifo.sv
module yc422_fifo
  import yc422_pkg::*;
#(
  parameter int EW    = 18,
  parameter int DEPTH = 4,
  localparam int AW   = ptr_bits(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [EW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [EW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign do_wr   = push_i && !full_o;
  assign do_rd   = pop_i && !empty_o;
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/yc422_out_stage.sv
module yc422_out_stage #(
  parameter int DW = 8,
  localparam int EW = 2 * DW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          empty_i,
  input  logic [EW-1:0] ent_i,
  input  logic          line_narrow_i,
  output logic          pop_o,
  output logic          half_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cbcr_o,
  output logic          dvld_o,
  output logic          active_o
);

  logic          e_narrow, e_active;
  logic [DW-1:0] e_c, e_y;
  logic          half_q;
  logic [DW-1:0] luma_hold_q;

  assign {e_narrow, e_active, e_c, e_y} = ent_i;
  assign pop_o  = !empty_i && !half_q;
  assign half_o = half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q      <= 1'b0;
      luma_hold_q <= '0;
      y_o         <= '0;
      cbcr_o      <= '0;
      dvld_o      <= 1'b0;
      active_o    <= 1'b0;
    end else if (half_q) begin
      y_o      <= luma_hold_q;
      dvld_o   <= 1'b1;
      active_o <= 1'b1;
      half_q   <= 1'b0;
    end else if (!empty_i) begin
      dvld_o <= 1'b1;
      if (e_narrow) begin
        y_o         <= e_c;
        luma_hold_q <= e_y;
        half_q      <= 1'b1;
        active_o    <= 1'b1;
      end else begin
        y_o      <= e_y;
        cbcr_o   <= e_c;
        active_o <= e_active;
      end
    end else begin
      dvld_o <= 1'b0;
      if (line_narrow_i) active_o <= 1'b1;
    end
  end

endmodule

// File: rtl/yc422_port_fmt.sv
module yc422_port_fmt #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic          sol_i,
  input  logic          in_valid_i,
  input  logic          in_active_i,
  input  logic [DW-1:0] in_y_i,
  input  logic [DW-1:0] in_cb_i,
  input  logic [DW-1:0] in_cr_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cbcr_o,
  output logic          dvld_o,
  output logic          active_o
);

  localparam int EW = 2 * DW + 2;

  logic          push_req, line_narrow, pop_req;
  logic          fifo_empty, fifo_full, ser_half;
  logic [EW-1:0] wr_ent, rd_ent;

  yc422_line_ctrl #(.DW(DW)) u_line (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sol_i(sol_i),
    .valid_i(in_valid_i), .active_i(in_active_i),
    .y_i(in_y_i), .cb_i(in_cb_i), .cr_i(in_cr_i),
    .push_o(push_req), .ent_o(wr_ent), .narrow_o(line_narrow)
  );

  yc422_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(push_req), .wdata_i(wr_ent),
    .pop_i(pop_req), .rdata_o(rd_ent), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  yc422_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .empty_i(fifo_empty), .ent_i(rd_ent),
    .line_narrow_i(line_narrow), .pop_o(pop_req), .half_o(ser_half),
    .y_o(y_o), .cbcr_o(cbcr_o), .dvld_o(dvld_o), .active_o(active_o)
  );

endmodule

// File: rtl/yc422_port_fmt_chk.sv
module yc422_port_fmt_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          dvld,
  input logic          active,
  input logic [DW-1:0] y,
  input logic [DW-1:0] cbcr,
  input logic          half,
  input logic          push,
  input logic          full,
  input logic          empty
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(push && full)); // R9

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dvld |-> ($stable(y) && $stable(cbcr))); // R7

  AST_NARROW_CHROMA_WORD: assert property (@(posedge clk) disable iff (rst)
    half |-> (dvld && active)); // R6

  AST_NARROW_LUMA_NEXT: assert property (@(posedge clk) disable iff (rst)
    half |=> (dvld && active && !half)); // R5

  AST_NO_SPURIOUS_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(dvld) |-> $past(!empty)); // R2

endmodule

bind yc422_port_fmt yc422_port_fmt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .dvld(dvld_o), .active(active_o),
  .y(y_o), .cbcr(cbcr_o), .half(ser_half), .push(push_req),
  .full(fifo_full), .empty(fifo_empty)
);

// File: tb/yc422_port_fmt_test.sv
`timescale 1ns/1ps
module yc422_port_fmt_test;

  localparam int DW = 8;
  localparam int NV = 36;
  localparam int MAXW = 128;

  // each entry {mode, sol, valid, active}; luma = 8'h10 + index
  localparam logic [3:0] VEC [NV] = '{
    4'b0111, 4'b0000, 4'b0010, 4'b0011, 4'b0011, 4'b0001, 4'b0011, 4'b1010,
    4'b1011, 4'b1110, 4'b1010, 4'b1011, 4'b1001, 4'b1011, 4'b0001, 4'b0011,
    4'b0000, 4'b0011, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b1100,
    4'b1011, 4'b1011, 4'b1011, 4'b1011, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
    4'b0111, 4'b0011, 4'b0010, 4'b0000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_i = 1'b0, sol_i = 1'b0, in_valid_i = 1'b0, in_active_i = 1'b0;
  logic [DW-1:0] in_y_i = '0, in_cb_i = '0, in_cr_i = '0;
  logic [DW-1:0] y_o, cbcr_o;
  logic dvld_o, active_o;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] ex_y [MAXW];
  logic [DW-1:0] ex_c [MAXW];
  logic          ex_a [MAXW];
  logic          ex_usec [MAXW];
  int            ne = 0;
  logic [DW-1:0] cp_y [MAXW];
  logic [DW-1:0] cp_c [MAXW];
  logic          cp_a [MAXW];
  int            nc = 0;

  logic m_mode = 1'b0;
  logic m_turn = 1'b0;

  always #2 clk = ~clk;

  yc422_port_fmt #(.DW(DW), .DEPTH(4)) uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sol_i(sol_i),
    .in_valid_i(in_valid_i), .in_active_i(in_active_i),
    .in_y_i(in_y_i), .in_cb_i(in_cb_i), .in_cr_i(in_cr_i),
    .y_o(y_o), .cbcr_o(cbcr_o), .dvld_o(dvld_o), .active_o(active_o)
  );

  always @(negedge clk) begin
    if (dvld_o && nc < MAXW) begin
      cp_y[nc] = y_o;
      cp_c[nc] = cbcr_o;
      cp_a[nc] = active_o;
      nc = nc + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [DW-1:0] y, input logic [DW-1:0] c,
                             input logic a, input logic usec);
    ex_y[ne] = y; ex_c[ne] = c; ex_a[ne] = a; ex_usec[ne] = usec;
    ne++;
  endtask

  // drive one cycle and predict the output words from the requirements
  task automatic step(input logic m, input logic s, input logic v, input logic a,
                      input logic [DW-1:0] y);
    logic [DW-1:0] cb, cr, ch;
    cb = y ^ 8'h55;
    cr = y ^ 8'hAA;
    mode_i = m; sol_i = s; in_valid_i = v; in_active_i = a;
    in_y_i = y; in_cb_i = cb; in_cr_i = cr;
    if (s) begin
      m_mode = m;
      m_turn = 1'b0;
    end
    ch = m_turn ? cr : cb;
    if (v && (!m_mode || a)) begin
      if (m_mode) begin            // R5: chroma word then luma word, R6 active high
        expect_word(ch, '0, 1'b1, 1'b0);
        expect_word(y, '0, 1'b1, 1'b0);
      end else begin               // R2, R3, R4
        expect_word(y, ch, a, 1'b1);
      end
      m_turn = ~m_turn;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!dvld_o && !active_o && y_o == 0 && cbcr_o == 0, "R1 reset",
          {dvld_o, active_o, y_o, cbcr_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 8'(8'h10 + i));
    end
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    check(nc == ne, "R2 R5 R8 R9 word count", nc, ne);
    for (int i = 0; i < ne; i++) begin
      if (i < nc) begin
        check(cp_y[i] == ex_y[i], "R2 R5 R9 y stream", cp_y[i], ex_y[i]);
        if (ex_usec[i])
          check(cp_c[i] == ex_c[i], "R3 chroma order", cp_c[i], ex_c[i]);
        check(cp_a[i] == ex_a[i], "R4 R6 active flag", cp_a[i], ex_a[i]);
      end
    end

    // R7: buses hold the last wide pixel (index 34, luma 8'h32, Cb turn)
    check(!dvld_o, "R7 idle", dvld_o, 0);
    check(y_o == 8'h32, "R7 y hold", y_o, 8'h32);
    check(cbcr_o == (8'h32 ^ 8'h55), "R7 cbcr hold", cbcr_o, 8'h32 ^ 8'h55);
    check(active_o == 1'b0, "R4 active hold", active_o, 0);

    // R6: narrow selected at a line start with no pixels, flag rises while idle
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check(active_o == 1'b1 && !dvld_o, "R6 idle active", {dvld_o, active_o}, 1);

    // R10: wide pixel on an empty path, output after the second edge
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hC3);
    check(!dvld_o, "R10 not yet", dvld_o, 0);
    @(negedge clk);
    check(dvld_o && y_o == 8'hC3, "R10 y after one more edge", y_o, 8'hC3);
    check(cbcr_o == (8'hC3 ^ 8'h55), "R3 first pixel of line is Cb", cbcr_o, 8'hC3 ^ 8'h55);

    // R1 again: reset mid-stream clears outputs
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h77);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!dvld_o && !active_o && y_o == 0, "R1 reset in flight",
          {dvld_o, active_o, y_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule